// File: doc/BRIEF.md
# Memory Field Extension Controller

This block holds the 3-bit instruction field (IF) and data field (DF) that widen a 12-bit processor's addresses to 15 bits. It watches each decoded instruction word. It acts on the field-group I/O instructions: changing either field, reading a field register into the accumulator, and saving or restoring the fields around an interrupt. It also gates the interrupt enable so that an enable instruction takes effect only after the instruction that follows it.

A change of instruction field does not take effect at once. The new value waits in a buffer, and a pending flag is set. The processor raises a jump strobe for every jump or subroutine call, at the point after that instruction's operand words have been read and before a call stores its return address. On that strobe the buffered field moves into IF and the pending flag clears. While the flag is set, the interrupt-hold output keeps the interrupt logic from entering the service routine. On interrupt entry the processor pulses a strobe. The block then saves both fields into a 6-bit save register and forces IF and DF to zero.

Bit positions below count from 0 at the least significant bit. All outputs are registered, so each input event shows on the outputs one clock later.

Top module: `mfx_ctrl`

## Requirements
- R1: After synchronous reset the following are all zero: IF, DF, the buffered field, the save register, the pending flag (irq_hold), irq_en and acc_wr.
- R2: A strobed word with instr[11:6]=octal 62 and instr[2:0]=1 loads instr[5:3] into DF and leaves IF unchanged. With instr[2:0]=3 the same load happens together with the R3 action.
- R3: A strobed word with instr[11:6]=octal 62 and instr[2:0]=2 (or 3) loads instr[5:3] into the buffer and sets irq_hold. IF keeps its value until a jump strobe arrives.
- R4: A jump strobe while irq_hold is set copies the buffer into IF and clears irq_hold. A jump strobe while irq_hold is clear changes nothing.
- R5: Read-DF (6214 octal) and read-IF (6224 octal) give acc_out = acc_in OR (field << 3) with acc_wr high, one cycle after the strobe. The other accumulator bits pass through unchanged.
- R6: Read-save (6234 octal) gives acc_out = acc_in OR save, where save[5:3] is the IF and save[2:0] is the DF that were current at the last interrupt entry.
- R7: Restore (6244 octal) loads save[2:0] into DF and save[5:3] into the buffer, and sets irq_hold. The next jump strobe moves the buffer into IF.
- R8: The interrupt-entry strobe captures {IF,DF} into the save register, zeroes IF and DF, and clears irq_en. In that cycle it overrides any decode or jump strobe, and the buffer and irq_hold are left as they were.
- R9: Enable-interrupts (6001 octal) raises irq_en only on the edge of the next instruction strobe. Disable-interrupts (6002 octal) clears irq_en and cancels an enable still waiting.
- R10: When a jump strobe and a change-instruction-field decode fall in the same cycle, IF takes the previously buffered value, the new field is buffered, and irq_hold stays set.
- R11: A word with instr_valid low, or a word outside the codes above, changes no register and leaves acc_wr low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Decode strobe for instr |
| instr | input | 12 | Instruction word being executed |
| acc_in | input | 12 | Current accumulator value |
| jmp_exec | input | 1 | Jump or call commit point |
| irq_entry | input | 1 | Interrupt entry strobe |
| acc_out | output | 12 | Accumulator value after a field read |
| acc_wr | output | 1 | acc_out is to be written back |
| ifield | output | 3 | Instruction field |
| dfield | output | 3 | Data field |
| irq_hold | output | 1 | Field change pending; hold off interrupts |
| irq_en | output | 1 | Interrupts enabled |

## Verification
The jump commit of an earlier field change can land in the same cycle as the decode of a new change-instruction-field word. The bench provokes this by buffering field 4, then strobing the jump together with a word that buffers field 1. It then expects IF=4 with irq_hold still set, and IF=1 only after a second jump. The bench also drives the interrupt-entry strobe together with a jump and a change-data-field word, and judges that entry wins: both fields go to zero, and a following read-save returns the fields from before entry.

// File: rtl/mfx_pkg.sv
package mfx_pkg;
  // one flag per field-group action; several may be set by a combined word
  typedef struct packed {
    logic set_df;
    logic set_ib;
    logic rd_df;
    logic rd_if;
    logic rd_sv;
    logic restore;
    logic ion;
    logic iof;
  } mfx_op_t;
endpackage

// File: rtl/mfx_decode.sv
module mfx_decode
  import mfx_pkg::*;
#(
  parameter int WORD_W  = 12,
  parameter int FIELD_W = 3
) (
  input  logic              valid,
  input  logic [WORD_W-1:0] instr,
  output mfx_op_t           op
);
  localparam int GRP_W = WORD_W - 2*FIELD_W;
  localparam logic [GRP_W-1:0]   GRP_FIELD = GRP_W'(6'o62);
  localparam logic [FIELD_W-1:0] SUB_DF    = FIELD_W'(1);
  localparam logic [FIELD_W-1:0] SUB_IB    = FIELD_W'(2);
  localparam logic [FIELD_W-1:0] SUB_BOTH  = FIELD_W'(3);
  localparam logic [FIELD_W-1:0] SUB_READ  = FIELD_W'(4);
  localparam logic [WORD_W-1:0]  W_ION     = WORD_W'(12'o6001);
  localparam logic [WORD_W-1:0]  W_IOF     = WORD_W'(12'o6002);

  logic [GRP_W-1:0]   grp;
  logic [FIELD_W-1:0] sel;
  logic [FIELD_W-1:0] sub;

  assign grp = instr[WORD_W-1 -: GRP_W];
  assign sel = instr[2*FIELD_W-1:FIELD_W];
  assign sub = instr[FIELD_W-1:0];

  always_comb begin
    op = '0;
    if (valid) begin
      op.ion = (instr == W_ION);
      op.iof = (instr == W_IOF);
      if (grp == GRP_FIELD) begin
        op.set_df = (sub == SUB_DF) || (sub == SUB_BOTH);
        op.set_ib = (sub == SUB_IB) || (sub == SUB_BOTH);
        if (sub == SUB_READ) begin
          op.rd_df   = (sel == FIELD_W'(1));
          op.rd_if   = (sel == FIELD_W'(2));
          op.rd_sv   = (sel == FIELD_W'(3));
          op.restore = (sel == FIELD_W'(4));
        end
      end
    end
  end
endmodule

// File: rtl/mfx_fields.sv
module mfx_fields
  import mfx_pkg::*;
#(
  parameter int FIELD_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  mfx_op_t              op,
  input  logic [FIELD_W-1:0]   code,
  input  logic                 jmp,
  input  logic                 irq,
  output logic [FIELD_W-1:0]   if_q,
  output logic [FIELD_W-1:0]   df_q,
  output logic [2*FIELD_W-1:0] save_q,
  output logic                 pend_q
);
  logic [FIELD_W-1:0] ib_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      if_q   <= '0;
      df_q   <= '0;
      ib_q   <= '0;
      save_q <= '0;
      pend_q <= 1'b0;
    end else if (irq) begin
      save_q <= {if_q, df_q};
      if_q   <= '0;
      df_q   <= '0;
    end else begin
      if (jmp && pend_q) begin
        if_q   <= ib_q;
        pend_q <= 1'b0;
      end
      if (op.set_df) df_q <= code;
      if (op.set_ib) begin
        ib_q   <= code;
        pend_q <= 1'b1;
      end
      if (op.restore) begin
        df_q   <= save_q[FIELD_W-1:0];
        ib_q   <= save_q[2*FIELD_W-1:FIELD_W];
        pend_q <= 1'b1;
      end
    end
  end

  // IF moves only at a jump commit or at interrupt entry
  assert_if_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (!jmp && !irq) |=> $stable(if_q));
  assert_commit_R4: assert property (@(posedge clk) disable iff (rst)
    (jmp && pend_q && !irq) |=> (if_q == $past(ib_q)));
  assert_entry_zero_R8: assert property (@(posedge clk) disable iff (rst)
    irq |=> (if_q == '0 && df_q == '0 && save_q == $past({if_q, df_q})));
  assert_set_pend_R3: assert property (@(posedge clk) disable iff (rst)
    ((op.set_ib || op.restore) && !irq) |=> pend_q);
endmodule

// File: rtl/mfx_acc_path.sv
module mfx_acc_path
  import mfx_pkg::*;
#(
  parameter int WORD_W  = 12,
  parameter int FIELD_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  mfx_op_t              op,
  input  logic                 irq,
  input  logic [WORD_W-1:0]    acc_in,
  input  logic [FIELD_W-1:0]   if_q,
  input  logic [FIELD_W-1:0]   df_q,
  input  logic [2*FIELD_W-1:0] save_q,
  output logic [WORD_W-1:0]    acc_out,
  output logic                 acc_we
);
  localparam int HI_W = WORD_W - 2*FIELD_W;

  logic [WORD_W-1:0] mask;
  logic              rd_any;

  assign rd_any = (op.rd_df || op.rd_if || op.rd_sv) && !irq;

  always_comb begin
    mask = '0;
    if (op.rd_df) mask = {{HI_W{1'b0}}, df_q, {FIELD_W{1'b0}}};
    if (op.rd_if) mask = {{HI_W{1'b0}}, if_q, {FIELD_W{1'b0}}};
    if (op.rd_sv) mask = {{HI_W{1'b0}}, save_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_out <= '0;
      acc_we  <= 1'b0;
    end else begin
      acc_we <= rd_any;
      if (rd_any) acc_out <= acc_in | mask;
    end
  end

  // a read never disturbs accumulator bits above the field slot
  assert_upper_kept_R5: assert property (@(posedge clk) disable iff (rst)
    rd_any |=> (acc_we && acc_out[WORD_W-1:2*FIELD_W] == $past(acc_in[WORD_W-1:2*FIELD_W])));
  assert_no_write_R11: assert property (@(posedge clk) disable iff (rst)
    !(op.rd_df || op.rd_if || op.rd_sv) |=> !acc_we);
endmodule

// File: rtl/mfx_irq_gate.sv
module mfx_irq_gate
  import mfx_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    valid,
  input  mfx_op_t op,
  input  logic    irq,
  output logic    irq_en
);
  logic arm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en <= 1'b0;
      arm_q  <= 1'b0;
    end else if (irq || op.iof) begin
      irq_en <= 1'b0;
      arm_q  <= 1'b0;
    end else if (op.ion) begin
      arm_q <= 1'b1;
    end else if (valid && arm_q) begin
      irq_en <= 1'b1;
      arm_q  <= 1'b0;
    end
  end

  assert_delayed_on_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_en) |-> ($past(valid) && !$past(op.ion)));
  assert_off_now_R9: assert property (@(posedge clk) disable iff (rst)
    (op.iof || irq) |=> !irq_en);
endmodule

// File: rtl/mfx_ctrl.sv
module mfx_ctrl
  import mfx_pkg::*;
#(
  parameter int WORD_W  = 12,
  parameter int FIELD_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instr_valid,
  input  logic [WORD_W-1:0]  instr,
  input  logic [WORD_W-1:0]  acc_in,
  input  logic               jmp_exec,
  input  logic               irq_entry,
  output logic [WORD_W-1:0]  acc_out,
  output logic               acc_wr,
  output logic [FIELD_W-1:0] ifield,
  output logic [FIELD_W-1:0] dfield,
  output logic               irq_hold,
  output logic               irq_en
);
  localparam int SAVE_W = 2*FIELD_W;

  mfx_op_t           op;
  logic [SAVE_W-1:0] save_q;

  mfx_decode #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) u_decode (
    .valid (instr_valid),
    .instr (instr),
    .op    (op)
  );

  mfx_fields #(.FIELD_W(FIELD_W)) u_fields (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .code   (instr[SAVE_W-1:FIELD_W]),
    .jmp    (jmp_exec),
    .irq    (irq_entry),
    .if_q   (ifield),
    .df_q   (dfield),
    .save_q (save_q),
    .pend_q (irq_hold)
  );

  mfx_acc_path #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .irq     (irq_entry),
    .acc_in  (acc_in),
    .if_q    (ifield),
    .df_q    (dfield),
    .save_q  (save_q),
    .acc_out (acc_out),
    .acc_we  (acc_wr)
  );

  mfx_irq_gate u_gate (
    .clk    (clk),
    .rst    (rst),
    .valid  (instr_valid),
    .op     (op),
    .irq    (irq_entry),
    .irq_en (irq_en)
  );

  // same-cycle commit and new buffer keeps the hold raised
  assert_overlap_R10: assert property (@(posedge clk) disable iff (rst)
    (jmp_exec && irq_hold && op.set_ib && !irq_entry) |=> irq_hold);
endmodule

// File: tb/mfx_ctrl_tb.sv
`timescale 1ns/1ps
module mfx_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        instr_valid;
  logic [11:0] instr;
  logic [11:0] acc_in;
  logic        jmp_exec;
  logic        irq_entry;
  logic [11:0] acc_out;
  logic        acc_wr;
  logic [2:0]  ifield;
  logic [2:0]  dfield;
  logic        irq_hold;
  logic        irq_en;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  mfx_ctrl u_dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .acc_in(acc_in), .jmp_exec(jmp_exec), .irq_entry(irq_entry),
    .acc_out(acc_out), .acc_wr(acc_wr), .ifield(ifield), .dfield(dfield),
    .irq_hold(irq_hold), .irq_en(irq_en)
  );

  // {req, valid, instr, acc_in, jmp, irq, exp_if, exp_df, exp_hold, exp_wr, exp_acc}
  localparam int NV = 17;
  localparam logic [50:0] TAB [0:NV-1] = '{
    {4'd2,  1'b1, 12'o6251, 12'o0000, 1'b0, 1'b0, 3'd0, 3'd5, 1'b0, 1'b0, 12'o0000}, // R2
    {4'd5,  1'b1, 12'o6214, 12'o7007, 1'b0, 1'b0, 3'd0, 3'd5, 1'b0, 1'b1, 12'o7057}, // R5
    {4'd3,  1'b1, 12'o6232, 12'o0000, 1'b0, 1'b0, 3'd0, 3'd5, 1'b1, 1'b0, 12'o0000}, // R3
    {4'd3,  1'b1, 12'o6224, 12'o0000, 1'b0, 1'b0, 3'd0, 3'd5, 1'b1, 1'b1, 12'o0000}, // R3
    {4'd4,  1'b0, 12'o0000, 12'o0000, 1'b1, 1'b0, 3'd3, 3'd5, 1'b0, 1'b0, 12'o0000}, // R4
    {4'd5,  1'b1, 12'o6224, 12'o4000, 1'b0, 1'b0, 3'd3, 3'd5, 1'b0, 1'b1, 12'o4030}, // R5
    {4'd4,  1'b0, 12'o0000, 12'o0000, 1'b1, 1'b0, 3'd3, 3'd5, 1'b0, 1'b0, 12'o0000}, // R4
    {4'd2,  1'b1, 12'o6273, 12'o0000, 1'b0, 1'b0, 3'd3, 3'd7, 1'b1, 1'b0, 12'o0000}, // R2
    {4'd4,  1'b0, 12'o0000, 12'o0000, 1'b1, 1'b0, 3'd7, 3'd7, 1'b0, 1'b0, 12'o0000}, // R4
    {4'd2,  1'b1, 12'o6221, 12'o0000, 1'b0, 1'b0, 3'd7, 3'd2, 1'b0, 1'b0, 12'o0000}, // R2
    {4'd8,  1'b0, 12'o0000, 12'o0000, 1'b0, 1'b1, 3'd0, 3'd0, 1'b0, 1'b0, 12'o0000}, // R8
    {4'd6,  1'b1, 12'o6234, 12'o0000, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 12'o0072}, // R6
    {4'd6,  1'b1, 12'o6234, 12'o7700, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 12'o7772}, // R6
    {4'd11, 1'b0, 12'o6251, 12'o0000, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 12'o0000}, // R11
    {4'd11, 1'b1, 12'o6205, 12'o0000, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 12'o0000}, // R11
    {4'd7,  1'b1, 12'o6244, 12'o0000, 1'b0, 1'b0, 3'd0, 3'd2, 1'b1, 1'b0, 12'o0000}, // R7
    {4'd7,  1'b0, 12'o0000, 12'o0000, 1'b1, 1'b0, 3'd7, 3'd2, 1'b0, 1'b0, 12'o0000}  // R7
  };

  task automatic check(input string req, input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_errors++;
      $display("FAIL %s %s: got %0o expected %0o", req, what, got, exp);
    end
  endtask

  task automatic step(input logic v, input logic [11:0] w, input logic [11:0] a,
                      input logic j, input logic q);
    @(negedge clk);
    instr_valid = v; instr = w; acc_in = a; jmp_exec = j; irq_entry = q;
    @(posedge clk);
    #1;
    @(negedge clk);
    instr_valid = 1'b0; jmp_exec = 1'b0; irq_entry = 1'b0;
  endtask

  initial begin
    #200000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst = 1'b1; instr_valid = 1'b0; instr = '0; acc_in = '0;
    jmp_exec = 1'b0; irq_entry = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", "if", ifield, 0);
    check("R1", "df", dfield, 0);
    check("R1", "hold", irq_hold, 0);
    check("R1", "en", irq_en, 0);
    check("R1", "wr", acc_wr, 0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [50:0] v;
      string r;
      v = TAB[i];
      r = $sformatf("R%0d", v[50:47]);
      step(v[46], v[45:34], v[33:22], v[21], v[20]);
      // outputs were sampled inside step, 1 ns after the edge; still held
      check(r, $sformatf("vec%0d if", i), ifield, v[19:17]);
      check(r, $sformatf("vec%0d df", i), dfield, v[16:14]);
      check(r, $sformatf("vec%0d hold", i), irq_hold, v[13]);
      check(r, $sformatf("vec%0d wr", i), acc_wr, v[12]);
      if (v[12]) check(r, $sformatf("vec%0d acc", i), acc_out, v[11:0]);
    end

    // R10: commit of buffered 4 in the same cycle as buffering 1
    step(1'b1, 12'o6242, 12'o0, 1'b0, 1'b0);
    check("R10", "hold after buffer", irq_hold, 1);
    step(1'b1, 12'o6212, 12'o0, 1'b1, 1'b0);
    check("R10", "if after overlap", ifield, 4);
    check("R10", "hold after overlap", irq_hold, 1);
    step(1'b0, 12'o0, 12'o0, 1'b1, 1'b0);
    check("R10", "if second jump", ifield, 1);
    check("R10", "hold second jump", irq_hold, 0);

    // R8: entry wins over a same-cycle jump and data-field change
    step(1'b1, 12'o6252, 12'o0, 1'b0, 1'b0);    // buffer 5, IF=1, DF=2
    step(1'b1, 12'o6271, 12'o0, 1'b1, 1'b1);
    check("R8", "if on entry", ifield, 0);
    check("R8", "df on entry", dfield, 0);
    check("R8", "hold kept", irq_hold, 1);
    step(1'b1, 12'o6234, 12'o0, 1'b0, 1'b0);
    check("R8", "saved fields", acc_out, 12'o0012);
    step(1'b0, 12'o0, 12'o0, 1'b1, 1'b0);
    check("R8", "buffer survived", ifield, 5);

    // R9: enable delay, disable at once
    step(1'b1, 12'o6001, 12'o0, 1'b0, 1'b0);
    check("R9", "en right after enable", irq_en, 0);
    step(1'b1, 12'o7000, 12'o0, 1'b0, 1'b0);
    check("R9", "en after next instr", irq_en, 1);
    step(1'b1, 12'o6002, 12'o0, 1'b0, 1'b0);
    check("R9", "en after disable", irq_en, 0);
    step(1'b1, 12'o6001, 12'o0, 1'b0, 1'b0);
    step(1'b1, 12'o6002, 12'o0, 1'b0, 1'b0);
    step(1'b1, 12'o7000, 12'o0, 1'b0, 1'b0);
    check("R9", "enable cancelled", irq_en, 0);
    step(1'b1, 12'o6001, 12'o0, 1'b0, 1'b0);
    step(1'b1, 12'o7000, 12'o0, 1'b0, 1'b0);
    step(1'b0, 12'o0, 12'o0, 1'b0, 1'b1);
    check("R8", "en cleared by entry", irq_en, 0);

    // R1: reset mid-run clears save register too
    step(1'b1, 12'o6242, 12'o0, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
    check("R1", "hold after reset", irq_hold, 0);
    step(1'b1, 12'o6234, 12'o0, 1'b0, 1'b0);
    check("R1", "save after reset", acc_out, 0);
    step(1'b0, 12'o0, 12'o0, 1'b1, 1'b0);
    check("R1", "buffer after reset", ifield, 0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule